// File: doc/BRIEF.md
# Two-Level Page Walk Translation Unit

This block turns a 14-bit virtual address into a physical address for 64-byte pages. A four-entry, fully associative translation cache is looked up first. When it has no entry for the page, a hardware walker reads two levels of translation tables through a single read port that allows one outstanding read. The first read fetches a directory entry. If that entry is valid, the second read fetches the page's own table entry. A walk that finds a valid and permitted mapping fills the cache and then replays the lookup, so every successful translation is returned by the cache.

A client presents an address and an access kind (read, write or execute) and waits for a one-cycle response. The response carries a physical address, or one of three fault codes: missing directory entry, missing table entry, or protection violation. The directory base is an input that software drives. A flush input drops every cached translation in one cycle.

Top module: `ptWalkMmu`

## Requirements
- R1: The virtual page number is address bits [13:6] and the page offset is bits [5:0]. Bits [13:10] pick one of 16 directory entries, and bits [9:6] pick one of 16 entries in the table page that the directory entry names.
- R2: The first read of a walk goes to address `dirBase + 4 * dirIndex`.
- R3: The second read of a walk goes to address `(directoryPfn << 6) + 4 * tableIndex`.
- R4: If the directory entry is invalid, the walk ends after exactly one read with fault code 1.
- R5: If the directory entry is valid and the table entry is invalid, the walk ends after exactly two reads with fault code 2.
- R6: If the table entry is valid but does not grant the requested access, the response is fault code 3 and no translation is cached. A repeat of the same request walks again.
- R7: A successful walk caches the translation and replays the lookup. The response is fault code 0 with physical address `(pfn << 6) | offset`, after exactly two reads.
- R8: A cache hit issues no read. A hit whose access is not granted gives fault code 3.
- R9: Entry layout: bit 0 is valid, bit 1 grants read, bit 2 grants write, bit 3 grants execute, and bits [15:4] hold the frame number. The access code is 0 for read, 1 for write and 2 for execute; code 3 is never granted. The permission bits of a directory entry are ignored.
- R10: Raising `tlbFlush` for one cycle invalidates every cached translation, so the next request to any page walks.
- R11: The cache holds 4 translations and refills slots in round-robin order. The fifth distinct page evicts the oldest fill.
- R12: `memReq` stays high with a stable `memAddr` from the start of a read until the cycle in which `memValid` returns. No other read is outstanding in that time.
- R13: `reqReady` is high only when the unit is idle. Each accepted request gets exactly one `rspValid` pulse. A faulting response carries physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Unit idle and accepting a request |
| reqVaddr | input | 14 | Virtual address |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 18 | Physical address, 0 on a fault |
| rspFault | output | 2 | 0 ok, 1 directory miss, 2 table miss, 3 protection |
| dirBase | input | 18 | Physical byte address of the directory |
| tlbFlush | input | 1 | Invalidate all cached translations |
| memReq | output | 1 | Table read request, held until memValid |
| memAddr | output | 18 | Table read byte address |
| memValid | input | 1 | Read data returned |
| memData | input | 16 | Returned table or directory entry |

## Verification
The checker watches the protocol on every cycle. It checks that a pending read holds its address, that responses pair one-to-one with accepted requests, that the port is never read while the unit is idle, and that each fault code comes with the matching number of reads. Which frame a page maps to, which addresses a walk reads, whether a protection fault left the cache untouched, and which slot a refill evicts can only be seen from the bench's scenarios. The bench reads those from response data and from read counts taken across chosen request sequences, including a sweep of every page under every access kind.

// File: rtl/ptWalkPkg.sv
package ptWalkPkg;
  localparam int VA_W   = 14;
  localparam int OFF_W  = 6;
  localparam int IDX_W  = 4;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 12;
  localparam int PERM_W = 3;
  localparam int ENT_W  = PFN_W + PERM_W + 1;
  localparam int PA_W   = PFN_W + OFF_W;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2, ACC_NONE = 2'd3} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_DIR = 2'd1, FLT_TBL = 2'd2, FLT_PROT = 2'd3} flt_e;

  typedef struct packed {
    logic capReq;
    logic selPte;
    logic latchPde;
    logic tlbIns;
    logic rspLoad;
    flt_e rspCode;
  } ctrl_t;

  function automatic logic permOk(input logic [PERM_W-1:0] perm, input acc_e acc);
    case (acc)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ptWalkTlb.sv
module ptWalkTlb
  import ptWalkPkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [VPN_W-1:0]  lookVpn,
  input  logic              ins,
  input  logic [VPN_W-1:0]  insVpn,
  input  logic [PFN_W-1:0]  insPfn,
  input  logic [PERM_W-1:0] insPerm,
  output logic              hit,
  output logic [PFN_W-1:0]  hitPfn,
  output logic [PERM_W-1:0] hitPerm
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ  [ENTRIES];
  logic [PERM_W-1:0]  permQ [ENTRIES];
  logic [PTR_W-1:0]   ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (vpnQ[g] == lookVpn);
  end

  always_comb begin
    hit     = |match;
    hitPfn  = '0;
    hitPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hitPfn  = hitPfn | pfnQ[i];
        hitPerm = hitPerm | permQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (ins) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins && !flush) begin
      vpnQ[ptr]  <= insVpn;
      pfnQ[ptr]  <= insPfn;
      permQ[ptr] <= insPerm;
    end
  end
endmodule

// File: rtl/ptWalkDatapath.sv
module ptWalkDatapath
  import ptWalkPkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic             flush,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [PA_W-1:0]  dirBase,
  input  logic [ENT_W-1:0] memData,
  output logic [PA_W-1:0]  memAddr,
  output logic             tlbHit,
  output logic             hitOk,
  output logic             entValid,
  output logic             entPermOk,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic [1:0]       rspFault
);
  logic [VA_W-1:0]   vaReg;
  acc_e              accReg;
  logic [PFN_W-1:0]  pdePfn;
  logic [PFN_W-1:0]  hitPfn;
  logic [PERM_W-1:0] hitPerm;
  logic [IDX_W-1:0]  dirIdx;
  logic [IDX_W-1:0]  tblIdx;
  logic [PA_W-1:0]   pdeAddr;
  logic [PA_W-1:0]   pteAddr;

  assign dirIdx  = vaReg[VA_W-1 -: IDX_W];
  assign tblIdx  = vaReg[OFF_W +: IDX_W];
  assign pdeAddr = dirBase + PA_W'({dirIdx, 2'b00});
  assign pteAddr = {pdePfn, {OFF_W{1'b0}}} + PA_W'({tblIdx, 2'b00});
  assign memAddr = ctl.selPte ? pteAddr : pdeAddr;

  assign entValid  = memData[0];
  assign entPermOk = permOk(memData[PERM_W:1], accReg);
  assign hitOk     = permOk(hitPerm, accReg);

  ptWalkTlb #(.ENTRIES(TLB_ENTRIES)) tlb_i (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (flush),
    .lookVpn (vaReg[VA_W-1:OFF_W]),
    .ins     (ctl.tlbIns),
    .insVpn  (vaReg[VA_W-1:OFF_W]),
    .insPfn  (memData[ENT_W-1 -: PFN_W]),
    .insPerm (memData[PERM_W:1]),
    .hit     (tlbHit),
    .hitPfn  (hitPfn),
    .hitPerm (hitPerm)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg  <= '0;
      accReg <= ACC_READ;
      pdePfn <= '0;
    end else begin
      if (ctl.capReq) begin
        vaReg  <= reqVaddr;
        accReg <= acc_e'(reqAccess);
      end
      if (ctl.latchPde) pdePfn <= memData[ENT_W-1 -: PFN_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspFault <= FLT_NONE;
    end else begin
      rspValid <= ctl.rspLoad;
      if (ctl.rspLoad) begin
        rspFault <= ctl.rspCode;
        rspPaddr <= (ctl.rspCode == FLT_NONE) ? {hitPfn, vaReg[OFF_W-1:0]} : '0;
      end
    end
  end
endmodule

// File: rtl/ptWalkCtrl.sv
module ptWalkCtrl
  import ptWalkPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  tlbHit,
  input  logic  hitOk,
  input  logic  memValid,
  input  logic  entValid,
  input  logic  entPermOk,
  output ctrl_t ctl,
  output logic  reqReady,
  output logic  memReq
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_DIR, S_TBL, S_RESP} state_e;
  state_e state, nextState;

  always_comb begin
    ctl       = '0;
    ctl.rspCode = FLT_NONE;
    nextState = state;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capReq = 1'b1;
          nextState  = S_LOOK;
        end
      end
      S_LOOK: begin
        if (tlbHit) begin
          ctl.rspLoad = 1'b1;
          ctl.rspCode = hitOk ? FLT_NONE : FLT_PROT;
          nextState   = S_RESP;
        end else begin
          nextState = S_DIR;
        end
      end
      S_DIR: begin
        memReq = 1'b1;
        if (memValid) begin
          if (!entValid) begin
            ctl.rspLoad = 1'b1;
            ctl.rspCode = FLT_DIR;
            nextState   = S_RESP;
          end else begin
            ctl.latchPde = 1'b1;
            nextState    = S_TBL;
          end
        end
      end
      S_TBL: begin
        memReq     = 1'b1;
        ctl.selPte = 1'b1;
        if (memValid) begin
          if (!entValid) begin
            ctl.rspLoad = 1'b1;
            ctl.rspCode = FLT_TBL;
            nextState   = S_RESP;
          end else if (!entPermOk) begin
            ctl.rspLoad = 1'b1;
            ctl.rspCode = FLT_PROT;
            nextState   = S_RESP;
          end else begin
            ctl.tlbIns = 1'b1;
            nextState  = S_LOOK;
          end
        end
      end
      S_RESP:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/ptWalkMmu.sv
module ptWalkMmu
  import ptWalkPkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [13:0] reqVaddr,
  input  logic [1:0]  reqAccess,
  output logic        rspValid,
  output logic [17:0] rspPaddr,
  output logic [1:0]  rspFault,
  input  logic [17:0] dirBase,
  input  logic        tlbFlush,
  output logic        memReq,
  output logic [17:0] memAddr,
  input  logic        memValid,
  input  logic [15:0] memData
);
  ctrl_t ctl;
  logic  tlbHit, hitOk, entValid, entPermOk;

  ptWalkCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .tlbHit    (tlbHit),
    .hitOk     (hitOk),
    .memValid  (memValid),
    .entValid  (entValid),
    .entPermOk (entPermOk),
    .ctl       (ctl),
    .reqReady  (reqReady),
    .memReq    (memReq)
  );

  ptWalkDatapath #(.TLB_ENTRIES(TLB_ENTRIES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .flush     (tlbFlush),
    .reqVaddr  (reqVaddr),
    .reqAccess (reqAccess),
    .dirBase   (dirBase),
    .memData   (memData),
    .memAddr   (memAddr),
    .tlbHit    (tlbHit),
    .hitOk     (hitOk),
    .entValid  (entValid),
    .entPermOk (entPermOk),
    .rspValid  (rspValid),
    .rspPaddr  (rspPaddr),
    .rspFault  (rspFault)
  );
endmodule

// File: rtl/ptWalkChecker.sv
module ptWalkChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic [17:0] rspPaddr,
  input logic [1:0]  rspFault,
  input logic        memReq,
  input logic [17:0] memAddr,
  input logic        memValid
);
  logic       pending;
  logic [2:0] rdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      rdCnt   <= '0;
    end else begin
      if (reqValid && reqReady) pending <= 1'b1;
      else if (rspValid)        pending <= 1'b0;
      if (reqValid && reqReady)         rdCnt <= '0;
      else if (memValid && rdCnt != 3'd7) rdCnt <= rdCnt + 3'd1;
    end
  end

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));
  assert_rsp_paired_R13: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> pending);
  assert_busy_not_ready_R13: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !reqReady);
  assert_fault_pa_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPaddr == '0));
  assert_idle_no_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> !memReq);
  assert_dir_fault_one_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd1) |-> (rdCnt == 3'd1));
  assert_tbl_fault_two_reads_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd2) |-> (rdCnt == 3'd2));
  assert_ok_never_one_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd0) |-> (rdCnt != 3'd1));
endmodule

bind ptWalkMmu ptWalkChecker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspPaddr (rspPaddr),
  .rspFault (rspFault),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memValid (memValid)
);

// File: tb/ptWalkMmu_tb_top.sv
`timescale 1ns/1ps
module ptWalkMmu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [13:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        rspValid;
  logic [17:0] rspPaddr;
  logic [1:0]  rspFault;
  logic [17:0] dirBase = 18'd12800;
  logic        tlbFlush = 1'b0;
  logic        memReq;
  logic [17:0] memAddr;
  logic        memValid = 1'b0;
  logic [15:0] memData = '0;

  int nVec = 0;
  int nFail = 0;
  int rdCount = 0;
  logic [17:0] rdLog [2];
  logic [15:0] memImg [int];

  always #5 clk = ~clk;

  ptWalkMmu dut_i (.*);

  function automatic logic [15:0] rdMem(input int a);
    return memImg.exists(a) ? memImg[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] mkEnt(input int pfn, input logic [2:0] perm);
    return {pfn[11:0], perm, 1'b1};
  endfunction

  // memory model: 2-cycle latency, one read at a time
  logic busy = 1'b0;
  int   cnt = 0;
  logic [17:0] capAddr = '0;
  always @(posedge clk) begin
    memValid <= 1'b0;
    if (!busy && memReq && !memValid) begin
      busy    <= 1'b1;
      cnt     <= 1;
      capAddr <= memAddr;
    end else if (busy) begin
      if (cnt == 0) begin
        memValid <= 1'b1;
        memData  <= rdMem(int'(capAddr));
        busy     <= 1'b0;
        rdLog[rdCount % 2] <= capAddr;
        rdCount  <= rdCount + 1;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReq(input int va, input int acc, output int flt, output int pa, output int reads);
    int startRd;
    int guard;
    @(negedge clk);
    startRd   = rdCount;
    reqVaddr  = 14'(va);
    reqAccess = 2'(acc);
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    guard = 0;
    while (!rspValid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (!rspValid) chk("R13 watchdog: no response", 0, 1);
    flt   = int'(rspFault);
    pa    = int'(rspPaddr);
    reads = rdCount - startRd;
  endtask

  task automatic flush();
    @(negedge clk);
    tlbFlush = 1'b1;
    @(negedge clk);
    tlbFlush = 1'b0;
  endtask

  // expected result from the table image and the requirement rules
  task automatic expect_walk(input int va, input int acc, output int flt, output int pa, output int reads);
    logic [15:0] pde, pte;
    logic [2:0]  perm;
    logic        ok;
    pde = rdMem(int'(dirBase) + 4 * ((va >> 10) & 15));
    pa = 0;
    if (!pde[0]) begin flt = 1; reads = 1; return; end
    reads = 2;
    pte = rdMem(int'(pde[15:4]) * 64 + 4 * ((va >> 6) & 15));
    if (!pte[0]) begin flt = 2; return; end
    perm = pte[3:1];
    ok = (acc == 0) ? perm[0] : (acc == 1) ? perm[1] : (acc == 2) ? perm[2] : 1'b0;
    if (!ok) begin flt = 3; return; end
    flt = 0;
    pa = int'(pte[15:4]) * 64 + (va & 63);
  endtask

  initial begin
    #1_500_000;
    chk("watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    int f, p, r;
    // R9: directory entries carry no permissions; perm bit0 read, bit1 write, bit2 exec
    memImg[12800 + 4*0]  = mkEnt(100, 3'b000);
    memImg[12800 + 4*15] = mkEnt(101, 3'b000);
    memImg[100*64 + 4*0] = mkEnt(10, 3'b101);
    memImg[100*64 + 4*1] = mkEnt(23, 3'b101);
    memImg[100*64 + 4*4] = mkEnt(80, 3'b011);
    memImg[100*64 + 4*5] = mkEnt(59, 3'b011);
    memImg[101*64 + 4*14] = mkEnt(55, 3'b011);
    memImg[101*64 + 4*15] = mkEnt(45, 3'b011);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 reset reqReady", int'(reqReady), 1);
    chk("R13 reset rspValid", int'(rspValid), 0);
    chk("R12 reset memReq", int'(memReq), 0);

    doReq(16'h3F80, 0, f, p, r);
    chk("R7 0x3F80 fault", f, 0);
    chk("R7 0x3F80 pa", p, 3520);
    chk("R7 0x3F80 reads", r, 2);
    chk("R2 directory read addr", int'(rdLog[0]), 12860);
    chk("R3 table read addr", int'(rdLog[1]), 6520);

    doReq(16'h3F85, 0, f, p, r);
    chk("R8 hit pa", p, 3525);
    chk("R8 hit reads", r, 0);
    doReq(16'h3F80, 2, f, p, r);
    chk("R8 hit prot fault", f, 3);
    chk("R8 hit prot reads", r, 0);
    chk("R13 fault pa zero", p, 0);

    doReq(0, 2, f, p, r);
    chk("R9 exec va0 pa", p, 640);
    chk("R9 exec va0 fault", f, 0);
    doReq(0, 3, f, p, r);
    chk("R9 access code 3 denied", f, 3);
    doReq(320, 0, f, p, r);
    chk("R7 va320 pa", p, 3776);

    doReq(128, 0, f, p, r);
    chk("R5 table miss fault", f, 2);
    chk("R5 table miss reads", r, 2);
    doReq(8192, 0, f, p, r);
    chk("R4 directory miss fault", f, 1);
    chk("R4 directory miss reads", r, 1);

    doReq(64, 1, f, p, r);
    chk("R6 walk prot fault", f, 3);
    chk("R6 walk prot reads", r, 2);
    doReq(64, 1, f, p, r);
    chk("R6 no insert: walks again", r, 2);
    doReq(64, 0, f, p, r);
    chk("R6 read after prot pa", p, 1472);
    chk("R6 read after prot reads", r, 2);

    flush();
    doReq(64, 0, f, p, r);
    chk("R10 flushed page walks", r, 2);
    doReq(16'h3F80, 0, f, p, r);
    chk("R10 flushed 0x3F80 walks", r, 2);

    // R11 round robin eviction
    flush();
    doReq(0, 0, f, p, r);
    doReq(64, 0, f, p, r);
    doReq(256, 0, f, p, r);
    doReq(320, 0, f, p, r);
    doReq(254 * 64, 0, f, p, r);
    chk("R11 fifth page walks", r, 2);
    doReq(64, 0, f, p, r);
    chk("R11 second fill kept", r, 0);
    doReq(0, 0, f, p, r);
    chk("R11 oldest evicted", r, 2);
    doReq(256, 0, f, p, r);
    chk("R11 third fill kept", r, 0);

    // R1 sweep: every page, every access kind, walk from empty cache
    for (int vpn = 0; vpn < 256; vpn++) begin
      for (int acc = 0; acc < 3; acc++) begin
        int ef, ep, er, va;
        va = vpn * 64 + int'($urandom_range(0, 63));
        flush();
        expect_walk(va, acc, ef, ep, er);
        doReq(va, acc, f, p, r);
        chk("R1 sweep fault", f, ef);
        chk("R1 sweep pa", p, ep);
        chk("R1 sweep reads", r, er);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule